// File: doc/BRIEF.md
# Directory Home Node Controller

This block is the home node for a set of cache lines shared by a few cores on a point-to-point network. For every line it keeps a directory entry: a coherence state, the core that holds a dirty copy, and a one-bit-per-core set of cores holding clean copies. Cores send read, read-exclusive and writeback requests to the home. The home answers from a small line memory when it can. When other cores hold copies, it sends probes (invalidate, recall or forward) only to those cores, never to all of them. It then gathers their responses before it completes the request.

While a probe is outstanding, the line sits in a busy state that holds the pending requester and the count of outstanding acknowledgements. Any new request to a busy line is refused with a negative acknowledgement, and the requester retries later. A read to a dirty line is served in one of two ways, chosen by a mode pin. In recall mode the home fetches the data itself (four hops). In forward mode the owner replies to the requester directly (three hops). A writeback from the owner that crosses a probe for the same line completes the transaction. The line ends Shared and no further acknowledgement is needed.

Each cycle the block accepts at most one input: either a core response or a request. Responses win, and a request is held off in any cycle that has a response. The block emits one registered message per cycle. Each message carries a destination mask, so a single invalidate can reach several sharers at once.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every line is Invalid, no message is emitted and `req_ready` is 1. A read-exclusive to a line after reset is granted at once, whatever the line held before reset.
- R2: A read (req type 0) to an Invalid or Shared line produces a data reply (msg type 0) one cycle later. The reply is sent to the requester only, carries the line memory value, and adds the requester to the sharers.
- R3: A read-exclusive (req type 1) to an Invalid line, or to a Shared line whose only sharer is the requester, produces an immediate grant (msg type 1) to the requester. The requester becomes the Modified owner.
- R4: A read-exclusive to a Shared line with other sharers sends one invalidate (msg type 3) whose destination mask holds exactly those other sharers. Each invalidate acknowledgement (rsp type 0) counts down, and no message is sent until the last one. The cycle after the last acknowledgement, a grant with the line memory data goes to the requester.
- R5: A writeback (req type 2) from the Modified owner stores its data in the line memory, makes the line Invalid and emits no message.
- R6: With `fwd_mode`=0, a read to a line Modified at another core sends a recall (msg type 4) to the owner only. The recall data response (rsp type 1) is written to memory and returned in a data reply to the requester. The requester is then the line's only sharer.
- R7: With `fwd_mode`=1, a read to a line Modified at another core sends a forward (msg type 5) to the owner only, with `msg_req` naming the requester. The forward acknowledgement (rsp type 2) updates memory, emits nothing, and leaves both the old owner and the requester as sharers.
- R8: Any read or read-exclusive to a line in a busy state is answered with a negative acknowledgement (msg type 2) to the requester, and the line's directory entry is left unchanged.
- R9: A writeback from the owner while its line awaits a recall or forward response writes memory and sends a data reply carrying the writeback data to the pending requester. The line ends Shared with the requester as its only sharer, and the owner's later response to the probe is ignored.
- R10: A read-exclusive to a line Modified at another core sends an invalidate to the owner only. The grant returns the data carried in the owner's acknowledgement, or the data of the owner's writeback if that writeback arrived first.
- R11: In any cycle with `rsp_valid`=1, `req_ready` is 0 and the request present is not consumed.
- R12: A response that does not match an outstanding probe of that line from that core emits no message and changes nothing.
- R13: A writeback from a core that is not the line's Modified owner is ignored, and the recorded owner is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_mode | input | 1 | 1: dirty reads are forwarded to the owner; 0: the home recalls the data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle (low while a response is present) |
| req_type | input | 2 | 0 read, 1 read-exclusive, 2 writeback |
| req_core | input | 2 | Requesting core id |
| req_addr | input | 4 | Line index |
| req_data | input | 8 | Writeback data |
| rsp_valid | input | 1 | Core response present |
| rsp_type | input | 2 | 0 invalidate ack, 1 recall data, 2 forward ack |
| rsp_core | input | 2 | Responding core id |
| rsp_addr | input | 4 | Line index |
| rsp_data | input | 8 | Line data carried by the response |
| msg_valid | output | 1 | Message emitted (registered) |
| msg_type | output | 3 | 0 data, 1 grant, 2 nack, 3 invalidate, 4 recall, 5 forward |
| msg_dest | output | 4 | Destination mask, one bit per core |
| msg_req | output | 2 | Requester the message serves |
| msg_addr | output | 4 | Line index |
| msg_data | output | 8 | Line data for data and grant messages |

## Verification
The main function is tried with sequences that drive one line through every state and probe path. Clean reads build a sharer set, and a read-exclusive then shows through its invalidate mask exactly which sharers were recorded. Recall and forward are each applied to a dirty line and followed by a read-exclusive. The invalidate mask that results shows which sharer set each mode left behind, and the grant data shows whether memory took the owner's data. The crossing cases (a writeback overtaking a forward, and a writeback overtaking an exclusive invalidate) are set against stray late responses. This tells apart a design that settles the race from one that waits for, or wrongly acts on, the old owner's reply.

// File: rtl/dir_pkg.sv
package dir_pkg;

  // request opcodes from cores
  localparam logic [1:0] RQ_RD  = 2'd0;
  localparam logic [1:0] RQ_RDX = 2'd1;
  localparam logic [1:0] RQ_WB  = 2'd2;

  // response opcodes from probed cores
  localparam logic [1:0] RS_INVACK = 2'd0;
  localparam logic [1:0] RS_RECALL = 2'd1;
  localparam logic [1:0] RS_FWDACK = 2'd2;

  typedef enum logic [2:0] {
    MSG_DATA   = 3'd0,
    MSG_GRANT  = 3'd1,
    MSG_NACK   = 3'd2,
    MSG_INV    = 3'd3,
    MSG_RECALL = 3'd4,
    MSG_FWD    = 3'd5
  } msg_e;

  typedef enum logic [2:0] {
    LS_I    = 3'd0,
    LS_S    = 3'd1,
    LS_M    = 3'd2,
    LS_BREC = 3'd3,  // waiting for recalled data
    LS_BFWD = 3'd4,  // waiting for forward ack
    LS_BXS  = 3'd5,  // exclusive pending, clean invalidations
    LS_BXM  = 3'd6   // exclusive pending, dirty owner invalidation
  } lstate_e;

endpackage

// File: rtl/dir_state_table.sv
module dir_state_table
  import dir_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int NLINE = 16,
  parameter int CW    = 2,
  parameter int AW    = 4,
  parameter int KW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             we,
  input  lstate_e          w_st,
  input  logic [CW-1:0]    w_own,
  input  logic [NCORE-1:0] w_shr,
  input  logic [CW-1:0]    w_pnd,
  input  logic [KW-1:0]    w_cnt,
  output lstate_e          r_st,
  output logic [CW-1:0]    r_own,
  output logic [NCORE-1:0] r_shr,
  output logic [CW-1:0]    r_pnd,
  output logic [KW-1:0]    r_cnt
);

  lstate_e          st_q  [NLINE];
  logic [CW-1:0]    own_q [NLINE];
  logic [NCORE-1:0] shr_q [NLINE];
  logic [CW-1:0]    pnd_q [NLINE];
  logic [KW-1:0]    cnt_q [NLINE];

  // only the state needs a reset; other fields are written before use
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NLINE; i++) st_q[i] <= LS_I;
    end else if (we) begin
      st_q[addr] <= w_st;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      own_q[addr] <= w_own;
      shr_q[addr] <= w_shr;
      pnd_q[addr] <= w_pnd;
      cnt_q[addr] <= w_cnt;
    end
  end

  assign r_st  = st_q[addr];
  assign r_own = own_q[addr];
  assign r_shr = shr_q[addr];
  assign r_pnd = pnd_q[addr];
  assign r_cnt = cnt_q[addr];

endmodule

// File: rtl/dir_line_mem.sv
module dir_line_mem #(
  parameter int NLINE = 16,
  parameter int DW    = 8,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem_q [NLINE];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  assign rdata = mem_q[addr];

endmodule

// File: rtl/dir_engine.sv
module dir_engine
  import dir_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int DW    = 8,
  parameter int CW    = 2,
  parameter int KW    = 3
) (
  input  logic             in_req,
  input  logic             in_rsp,
  input  logic [1:0]       in_typ,
  input  logic [CW-1:0]    in_core,
  input  logic [DW-1:0]    in_data,
  input  logic             fwd_mode,
  input  lstate_e          cur_st,
  input  logic [CW-1:0]    cur_own,
  input  logic [NCORE-1:0] cur_shr,
  input  logic [CW-1:0]    cur_pnd,
  input  logic [KW-1:0]    cur_cnt,
  input  logic [DW-1:0]    mem_rdata,
  output logic             tbl_we,
  output lstate_e          n_st,
  output logic [CW-1:0]    n_own,
  output logic [NCORE-1:0] n_shr,
  output logic [CW-1:0]    n_pnd,
  output logic [KW-1:0]    n_cnt,
  output logic             mem_we,
  output logic [DW-1:0]    mem_wdata,
  output logic             m_v,
  output msg_e             m_type,
  output logic [NCORE-1:0] m_dest,
  output logic [CW-1:0]    m_req,
  output logic [DW-1:0]    m_data
);

  logic [NCORE-1:0] core_oh, own_oh, pnd_oh, others;
  logic             busy;

  always_comb begin
    core_oh = '0; core_oh[in_core] = 1'b1;
    own_oh  = '0; own_oh[cur_own]  = 1'b1;
    pnd_oh  = '0; pnd_oh[cur_pnd]  = 1'b1;
    others  = cur_shr & ~core_oh;
    busy    = (cur_st == LS_BREC) || (cur_st == LS_BFWD) ||
              (cur_st == LS_BXS)  || (cur_st == LS_BXM);

    tbl_we = 1'b0; n_st = cur_st; n_own = cur_own; n_shr = cur_shr;
    n_pnd = cur_pnd; n_cnt = cur_cnt;
    mem_we = 1'b0; mem_wdata = in_data;
    m_v = 1'b0; m_type = MSG_DATA; m_dest = '0; m_req = in_core; m_data = mem_rdata;

    if (in_req) begin
      if (in_typ == RQ_RD || in_typ == RQ_RDX) begin
        if (busy) begin                          // R8: refuse, keep entry
          m_v = 1'b1; m_type = MSG_NACK; m_dest = core_oh;
        end else if (in_typ == RQ_RD) begin
          if (cur_st == LS_M && cur_own != in_core) begin
            tbl_we = 1'b1; n_pnd = in_core;      // R6 / R7: probe owner only
            m_v = 1'b1; m_dest = own_oh;
            if (fwd_mode) begin
              n_st = LS_BFWD; m_type = MSG_FWD;
            end else begin
              n_st = LS_BREC; m_type = MSG_RECALL;
            end
          end else if (cur_st == LS_M) begin
            m_v = 1'b1; m_dest = core_oh;        // owner re-read
          end else begin                          // R2
            tbl_we = 1'b1; n_st = LS_S;
            n_shr = (cur_st == LS_I) ? core_oh : (cur_shr | core_oh);
            m_v = 1'b1; m_dest = core_oh;
          end
        end else begin
          if (cur_st == LS_M && cur_own != in_core) begin   // R10
            tbl_we = 1'b1; n_st = LS_BXM; n_pnd = in_core;
            n_shr = own_oh; n_cnt = KW'(1);
            m_v = 1'b1; m_type = MSG_INV; m_dest = own_oh;
          end else if (cur_st == LS_S && others != '0) begin // R4
            tbl_we = 1'b1; n_st = LS_BXS; n_pnd = in_core;
            n_shr = others; n_cnt = KW'($countones(others));
            m_v = 1'b1; m_type = MSG_INV; m_dest = others;
          end else begin                                     // R3
            tbl_we = 1'b1; n_st = LS_M; n_own = in_core; n_shr = '0;
            m_v = 1'b1; m_type = MSG_GRANT; m_dest = core_oh;
          end
        end
      end else if (in_typ == RQ_WB && in_core == cur_own) begin
        if (cur_st == LS_M) begin                 // R5
          tbl_we = 1'b1; n_st = LS_I; n_shr = '0; mem_we = 1'b1;
        end else if (cur_st == LS_BREC || cur_st == LS_BFWD) begin  // R9
          tbl_we = 1'b1; n_st = LS_S; n_shr = pnd_oh; mem_we = 1'b1;
          m_v = 1'b1; m_type = MSG_DATA; m_dest = pnd_oh;
          m_req = cur_pnd; m_data = in_data;
        end else if (cur_st == LS_BXM) begin      // R10: data now clean
          tbl_we = 1'b1; n_st = LS_BXS; mem_we = 1'b1;
        end
      end
      // R13: other writebacks fall through untouched
    end else if (in_rsp) begin
      if (in_typ == RS_INVACK && (cur_st == LS_BXS || cur_st == LS_BXM) &&
          cur_shr[in_core]) begin
        tbl_we = 1'b1; n_shr = cur_shr & ~core_oh; n_cnt = cur_cnt - KW'(1);
        mem_we = (cur_st == LS_BXM);
        if (cur_cnt == KW'(1)) begin              // R4: last ack
          n_st = LS_M; n_own = cur_pnd; n_shr = '0;
          m_v = 1'b1; m_type = MSG_GRANT; m_dest = pnd_oh; m_req = cur_pnd;
          m_data = (cur_st == LS_BXM) ? in_data : mem_rdata;
        end
      end else if (in_typ == RS_RECALL && cur_st == LS_BREC && in_core == cur_own) begin
        tbl_we = 1'b1; n_st = LS_S; n_shr = pnd_oh; mem_we = 1'b1;
        m_v = 1'b1; m_type = MSG_DATA; m_dest = pnd_oh;
        m_req = cur_pnd; m_data = in_data;
      end else if (in_typ == RS_FWDACK && cur_st == LS_BFWD && in_core == cur_own) begin
        tbl_we = 1'b1; n_st = LS_S; n_shr = pnd_oh | own_oh; mem_we = 1'b1;
      end
      // R12: anything else is stale and dropped
    end
  end

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int NLINE = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(NCORE),
  localparam int AW   = $clog2(NLINE),
  localparam int KW   = $clog2(NCORE + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fwd_mode,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_type,
  input  logic [CW-1:0]    req_core,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_data,
  input  logic             rsp_valid,
  input  logic [1:0]       rsp_type,
  input  logic [CW-1:0]    rsp_core,
  input  logic [AW-1:0]    rsp_addr,
  input  logic [DW-1:0]    rsp_data,
  output logic             msg_valid,
  output logic [2:0]       msg_type,
  output logic [NCORE-1:0] msg_dest,
  output logic [CW-1:0]    msg_req,
  output logic [AW-1:0]    msg_addr,
  output logic [DW-1:0]    msg_data
);

  // R11: responses own the single input slot
  assign req_ready = !rsp_valid;

  logic          s_req, s_rsp;
  logic [1:0]    s_typ;
  logic [CW-1:0] s_core;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_data;

  always_comb begin
    s_rsp  = rsp_valid;
    s_req  = req_valid && !rsp_valid;
    s_typ  = rsp_valid ? rsp_type : req_type;
    s_core = rsp_valid ? rsp_core : req_core;
    s_addr = rsp_valid ? rsp_addr : req_addr;
    s_data = rsp_valid ? rsp_data : req_data;
  end

  lstate_e          c_st, w_st;
  logic [CW-1:0]    c_own, c_pnd, w_own, w_pnd;
  logic [NCORE-1:0] c_shr, w_shr;
  logic [KW-1:0]    c_cnt, w_cnt;
  logic             tbl_we, mem_we, m_v;
  logic [DW-1:0]    mem_rdata, mem_wdata, m_data;
  msg_e             m_type;
  logic [NCORE-1:0] m_dest;
  logic [CW-1:0]    m_req;

  dir_state_table #(.NCORE(NCORE), .NLINE(NLINE), .CW(CW), .AW(AW), .KW(KW)) u_tbl (
    .clk(clk), .rst(rst), .addr(s_addr), .we(tbl_we),
    .w_st(w_st), .w_own(w_own), .w_shr(w_shr), .w_pnd(w_pnd), .w_cnt(w_cnt),
    .r_st(c_st), .r_own(c_own), .r_shr(c_shr), .r_pnd(c_pnd), .r_cnt(c_cnt)
  );

  dir_line_mem #(.NLINE(NLINE), .DW(DW), .AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .addr(s_addr), .wdata(mem_wdata), .rdata(mem_rdata)
  );

  dir_engine #(.NCORE(NCORE), .DW(DW), .CW(CW), .KW(KW)) u_eng (
    .in_req(s_req), .in_rsp(s_rsp), .in_typ(s_typ), .in_core(s_core),
    .in_data(s_data), .fwd_mode(fwd_mode),
    .cur_st(c_st), .cur_own(c_own), .cur_shr(c_shr), .cur_pnd(c_pnd),
    .cur_cnt(c_cnt), .mem_rdata(mem_rdata),
    .tbl_we(tbl_we), .n_st(w_st), .n_own(w_own), .n_shr(w_shr), .n_pnd(w_pnd),
    .n_cnt(w_cnt), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .m_v(m_v), .m_type(m_type), .m_dest(m_dest), .m_req(m_req), .m_data(m_data)
  );

  // registered message port (R1: quiet after reset)
  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_type  <= '0;
      msg_dest  <= '0;
      msg_req   <= '0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      msg_valid <= m_v;
      msg_type  <= m_type;
      msg_dest  <= m_v ? m_dest : '0;
      msg_req   <= m_req;
      msg_addr  <= s_addr;
      msg_data  <= m_data;
    end
  end

endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk #(
  parameter int NCORE = 4,
  localparam int CW   = $clog2(NCORE)
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             msg_valid,
  input logic [2:0]       msg_type,
  input logic [NCORE-1:0] msg_dest,
  input logic [CW-1:0]    msg_req
);

  // R1: no message in the cycle after a reset cycle
  a_r1_quiet_after_reset: assert property (@(posedge clk) rst |=> !msg_valid);

  // R12: every message is caused by an input taken the cycle before
  a_r12_msg_has_cause: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> $past(rsp_valid || (req_valid && req_ready)));

  // R2 / R8: replies reach exactly one core
  a_r2_reply_single_dest: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_type <= 3'd2) |-> $onehot(msg_dest));

  // R4: invalidates never target the requester and are never empty
  a_r4_inv_not_requester: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_type == 3'd3) |-> (!msg_dest[msg_req] && msg_dest != '0));

  // R6 / R7: recall and forward go to the single owner
  a_r6_probe_single_owner: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && (msg_type == 3'd4 || msg_type == 3'd5)) |-> $onehot(msg_dest));

  // R11: no request is accepted alongside a response
  a_r11_ready_low_on_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(.NCORE(NCORE)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .msg_valid(msg_valid), .msg_type(msg_type),
  .msg_dest(msg_dest), .msg_req(msg_req)
);

// File: tb/dir_home_ctrl_tb_top.sv
module dir_home_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fwd_mode = 1'b0;
  logic       req_valid = 1'b0, rsp_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_type = '0, rsp_type = '0, req_core = '0, rsp_core = '0;
  logic [3:0] req_addr = '0, rsp_addr = '0;
  logic [7:0] req_data = '0, rsp_data = '0;
  logic       msg_valid;
  logic [2:0] msg_type;
  logic [3:0] msg_dest;
  logic [1:0] msg_req;
  logic [3:0] msg_addr;
  logic [7:0] msg_data;

  always #2 clk = ~clk;  // 250 MHz

  dir_home_ctrl dut_i (
    .clk(clk), .rst(rst), .fwd_mode(fwd_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_core(req_core), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_core(rsp_core),
    .rsp_addr(rsp_addr), .rsp_data(rsp_data),
    .msg_valid(msg_valid), .msg_type(msg_type), .msg_dest(msg_dest),
    .msg_req(msg_req), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  typedef struct packed {
    logic       src;   // 0 request, 1 response
    logic [1:0] typ;
    logic [1:0] core;
    logic [3:0] addr;
    logic [7:0] dat;
    logic       fwd;
    logic       ev;    // message expected
    logic [2:0] et;
    logic [3:0] ed;
    logic [1:0] er;
    logic [7:0] edat;
    logic       cd;    // check data
    logic [3:0] rq;    // requirement number
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    // line 1: build up and tear down sharers
    '{0,2'd1,2'd0,4'd1,8'h00,0, 1,3'd1,4'b0001,2'd0,8'h00,0,4'd3},  // R3 grant on Invalid
    '{0,2'd2,2'd0,4'd1,8'h5A,0, 0,3'd0,4'b0000,2'd0,8'h00,0,4'd5},  // R5 owner writeback silent
    '{0,2'd0,2'd1,4'd1,8'h00,0, 1,3'd0,4'b0010,2'd1,8'h5A,1,4'd2},  // R2 data from memory
    '{0,2'd0,2'd2,4'd1,8'h00,0, 1,3'd0,4'b0100,2'd2,8'h5A,1,4'd2},  // R2 second sharer
    '{0,2'd1,2'd3,4'd1,8'h00,0, 1,3'd3,4'b0110,2'd3,8'h00,0,4'd4},  // R4 multicast inv
    '{0,2'd0,2'd0,4'd1,8'h00,0, 1,3'd2,4'b0001,2'd0,8'h00,0,4'd8},  // R8 busy nack
    '{1,2'd0,2'd1,4'd1,8'h00,0, 0,3'd0,4'b0000,2'd0,8'h00,0,4'd4},  // R4 first ack silent
    '{1,2'd0,2'd2,4'd1,8'h00,0, 1,3'd1,4'b1000,2'd3,8'h5A,1,4'd4},  // R4 last ack grants
    '{0,2'd0,2'd0,4'd1,8'h00,0, 1,3'd4,4'b1000,2'd0,8'h00,0,4'd6},  // R6 recall to owner
    '{1,2'd1,2'd3,4'd1,8'h77,0, 1,3'd0,4'b0001,2'd0,8'h77,1,4'd6},  // R6 recalled data
    '{0,2'd1,2'd2,4'd1,8'h00,0, 1,3'd3,4'b0001,2'd2,8'h00,0,4'd6},  // R6 sole sharer
    '{1,2'd0,2'd0,4'd1,8'h00,0, 1,3'd1,4'b0100,2'd2,8'h77,1,4'd4},
    '{0,2'd0,2'd1,4'd1,8'h00,1, 1,3'd5,4'b0100,2'd1,8'h00,0,4'd7},  // R7 forward
    '{1,2'd2,2'd2,4'd1,8'h88,1, 0,3'd0,4'b0000,2'd0,8'h00,0,4'd7},  // R7 fwd ack silent
    '{0,2'd1,2'd3,4'd1,8'h00,0, 1,3'd3,4'b0110,2'd3,8'h00,0,4'd7},  // R7 both sharers
    '{1,2'd0,2'd1,4'd1,8'h00,0, 0,3'd0,4'b0000,2'd0,8'h00,0,4'd4},
    '{1,2'd0,2'd2,4'd1,8'h00,0, 1,3'd1,4'b1000,2'd3,8'h88,1,4'd7},  // R7 memory updated
    // line 2: writeback crosses a forward
    '{0,2'd1,2'd1,4'd2,8'h00,0, 1,3'd1,4'b0010,2'd1,8'h00,0,4'd3},
    '{0,2'd0,2'd2,4'd2,8'h00,1, 1,3'd5,4'b0010,2'd2,8'h00,0,4'd9},
    '{0,2'd2,2'd1,4'd2,8'h3C,1, 1,3'd0,4'b0100,2'd2,8'h3C,1,4'd9},  // R9 race settles
    '{1,2'd2,2'd1,4'd2,8'h99,1, 0,3'd0,4'b0000,2'd0,8'h00,0,4'd12}, // R12 stale fwd ack
    '{0,2'd1,2'd0,4'd2,8'h00,0, 1,3'd3,4'b0100,2'd0,8'h00,0,4'd9},  // R9 requester only
    '{1,2'd0,2'd2,4'd2,8'h00,0, 1,3'd1,4'b0001,2'd0,8'h3C,1,4'd9},
    // line 3: exclusive against a dirty owner
    '{0,2'd1,2'd2,4'd3,8'h00,0, 1,3'd1,4'b0100,2'd2,8'h00,0,4'd3},
    '{0,2'd1,2'd0,4'd3,8'h00,0, 1,3'd3,4'b0100,2'd0,8'h00,0,4'd10}, // R10 inv owner
    '{1,2'd0,2'd2,4'd3,8'hE1,0, 1,3'd1,4'b0001,2'd0,8'hE1,1,4'd10}, // R10 dirty data
    '{0,2'd2,2'd1,4'd3,8'h11,0, 0,3'd0,4'b0000,2'd0,8'h00,0,4'd13}, // R13 foreign wb
    '{1,2'd0,2'd1,4'd3,8'h00,0, 0,3'd0,4'b0000,2'd0,8'h00,0,4'd12}, // R12 unsolicited ack
    '{0,2'd0,2'd3,4'd3,8'h00,0, 1,3'd4,4'b0001,2'd3,8'h00,0,4'd13}, // R13 owner kept
    '{1,2'd1,2'd0,4'd3,8'hE2,0, 1,3'd0,4'b1000,2'd3,8'hE2,1,4'd6},
    // line 4: writeback crosses an exclusive invalidate
    '{0,2'd1,2'd1,4'd4,8'h00,0, 1,3'd1,4'b0010,2'd1,8'h00,0,4'd3},
    '{0,2'd1,2'd3,4'd4,8'h00,0, 1,3'd3,4'b0010,2'd3,8'h00,0,4'd10},
    '{0,2'd2,2'd1,4'd4,8'h42,0, 0,3'd0,4'b0000,2'd0,8'h00,0,4'd10},
    '{1,2'd0,2'd1,4'd4,8'h00,0, 1,3'd1,4'b1000,2'd3,8'h42,1,4'd10},
    // line 5: requester is the only sharer
    '{0,2'd0,2'd2,4'd5,8'h00,0, 1,3'd0,4'b0100,2'd2,8'h00,0,4'd2},
    '{0,2'd1,2'd2,4'd5,8'h00,0, 1,3'd1,4'b0100,2'd2,8'h00,0,4'd3}
  };

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  task automatic check_msg(input vec_t v, input int idx);
    bit ok;
    n_chk++;
    ok = (msg_valid == v.ev);
    if (v.ev) begin
      ok = ok && (msg_type == v.et) && (msg_dest == v.ed) &&
           (msg_req == v.er) && (msg_addr == v.addr);
      if (v.cd) ok = ok && (msg_data == v.edat);
    end
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d step %0d: got v=%0b t=%0d d=%b r=%0d a=%0d dat=%h exp v=%0b t=%0d d=%b r=%0d a=%0d dat=%h",
               v.rq, idx, msg_valid, msg_type, msg_dest, msg_req, msg_addr, msg_data,
               v.ev, v.et, v.ed, v.er, v.addr, v.edat);
    end
  endtask

  task automatic apply(input vec_t v, input int idx);
    @(negedge clk);
    fwd_mode = v.fwd;
    if (v.src) begin
      rsp_valid = 1'b1; rsp_type = v.typ; rsp_core = v.core;
      rsp_addr = v.addr; rsp_data = v.dat;
    end else begin
      req_valid = 1'b1; req_type = v.typ; req_core = v.core;
      req_addr = v.addr; req_data = v.dat;
    end
    @(negedge clk);
    req_valid = 1'b0; rsp_valid = 1'b0;
    check_msg(v, idx);
  endtask

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    n_chk++;
    if (msg_valid !== 1'b0 || req_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 reset: got valid=%b ready=%b exp valid=0 ready=1", msg_valid, req_ready);
    end

    for (int i = 0; i < NV; i++) apply(VEC[i], i + 1);

    // R11: request present with a response is held off and not consumed
    @(negedge clk);
    rsp_valid = 1'b1; rsp_type = 2'd0; rsp_core = 2'd3; rsp_addr = 4'd6;
    req_valid = 1'b1; req_type = 2'd0; req_core = 2'd0; req_addr = 4'd6;
    #1;
    n_chk++;
    if (req_ready !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 ready: got %b exp 0", req_ready);
    end
    @(negedge clk);
    rsp_valid = 1'b0; req_valid = 1'b0;
    n_chk++;
    if (msg_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 consumed: got valid=%b exp 0", msg_valid);
    end

    // R1: reset clears directory state for line 1 (owner core 3 before)
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
    n_chk++;
    if (msg_valid !== 1'b0 || req_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 re-reset: got valid=%b ready=%b exp valid=0 ready=1", msg_valid, req_ready);
    end
    v = '{0,2'd1,2'd2,4'd1,8'h00,0, 1,3'd1,4'b0100,2'd2,8'h00,0,4'd1};
    apply(v, 100);
    v = '{0,2'd0,2'd0,4'd3,8'h00,0, 1,3'd0,4'b0001,2'd0,8'h00,0,4'd1};
    apply(v, 101);  // R1: line 3 Invalid again, read answered directly

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule